// File: doc/BRIEF.md
# GPIO Interrupt Channel Mux

This block picks a handful of pads out of a wide bank of general-purpose inputs and presents each one on its own interrupt channel. Every channel holds a pad selector and a trigger conditioner. The conditioner accepts five senses: level-high, level-low, rising edge, falling edge and both edges. It always hands the downstream interrupt controller an active-high signal. Level senses come out as a level. Edge senses come out as a one-cycle high pulse.

Software sets the block up through a word-wide register port: a write strobe, a byte address, 32-bit write data and registered read data. The pads are asynchronous. Each pad passes through a two-flop synchroniser before any channel selects it. An optional per-channel stability filter can reject short glitches. The register port is a plain control port with no handshake: a write completes in the cycle its strobe is sampled, and a read never stalls.

Top module: `gpio_irq_route`

## Requirements
- R1: After reset every register reads zero and every `irq_o` bit is low.
- R2: Configuration registers:
  - Word 0x00 holds, per channel n, an edge-enable bit at n, a both-edge bit at 8+n and an invert bit at 16+n. The other bits read zero.
  - Word 0x04 holds the 8-bit pad selects of channels 0-3, and word 0x08 holds those of channels 4-7. Each field sits at bit (n mod 4)*8.
  - Word 0x0c holds a 4-bit filter field per channel at bit n*4.
  - Read data appears on `cfg_rdata` one clock after the address is presented.
- R3: An address at or above 0x10, or one whose low two bits are not zero, reads as zero. A write to such an address changes no register.
- R4: With edge, both-edge and invert all clear, a channel is level-high. Its output equals the selected pad, three clock edges after the pad changes (two synchroniser flops plus one sample stage).
- R5: With only the invert bit set, the channel output is the complement of the selected pad (level-low).
- R6: With the edge bit set and both-edge clear, a rising edge of the selected pad gives exactly one high cycle, three edges after the pad rises. A falling edge gives no pulse.
- R7: With the edge and invert bits set, a falling edge gives a one-cycle pulse and a rising edge gives none.
- R8: With the both-edge bit set, every transition of the selected pad gives a one-cycle pulse. The edge and invert bits of that channel are then ignored.
- R9: A filter field F of zero adds no delay. When F is above zero, a new pad value is taken only after it has differed from the held value for 2*F consecutive sampled cycles. With F=2, a level held for 3 cycles is dropped, and a level held longer appears six edges after it is applied.
- R10: A new pad select takes effect on the output one edge after the write is sampled. The select fields of the other channels in the same word keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pad_i | input | NUM_PADS | Asynchronous pad inputs |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Byte address of the register word |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after the address |
| irq_o | output | NUM_CH | Active-high interrupt line per channel |

## Verification
Each sense is driven with an isolated rise and an isolated fall on its own channel:
- A level sense must follow or invert the pad.
- A single-edge sense must pulse on one direction only.
- Both-edge mode must pulse on both directions while its edge and invert bits are set.

Two channels toggled in the same cycle show that the channels stay independent. The filtered channel gets a pulse one cycle too short and then a long level, which separates rejection from acceptance. A pad reselect made while the old and new pads hold opposite values shows which pad the channel really follows.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int SEL_W    = 8;
  localparam int FILT_W   = 4;
  localparam int BOTH_OFS = 8;
  localparam int INV_OFS  = 16;
  localparam int WORD_MODE   = 0;
  localparam int WORD_SEL_LO = 1;
  localparam int WORD_SEL_HI = 2;
  localparam int WORD_FILT   = 3;
  localparam int WORD_COUNT  = 4;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_EDGE  = 2'd1,
    TRIG_BOTH  = 2'd2
  } trig_e;
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q_o  <= '0;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/gir_regs.sv
module gir_regs
  import gir_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [31:0]                      wdata_i,
  output logic [31:0]                      rdata_o,
  output logic [NUM_CH-1:0]                edge_en_o,
  output logic [NUM_CH-1:0]                both_en_o,
  output logic [NUM_CH-1:0]                inv_en_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]     sel_o,
  output logic [NUM_CH-1:0][FILT_W-1:0]    filt_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              hit;
  logic [31:0]       rd_next;

  assign word = addr_i[ADDR_W-1:2];
  assign hit  = (addr_i[1:0] == 2'b00) && (word < WORD_W'(WORD_COUNT));

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_en_o <= '0;
      both_en_o <= '0;
      inv_en_o  <= '0;
      sel_o     <= '0;
      filt_o    <= '0;
    end else if (we_i && hit) begin
      if (word == WORD_W'(WORD_MODE)) begin
        edge_en_o <= wdata_i[NUM_CH-1:0];
        both_en_o <= wdata_i[BOTH_OFS +: NUM_CH];
        inv_en_o  <= wdata_i[INV_OFS +: NUM_CH];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (word == WORD_W'(WORD_SEL_LO + c / 4))
          sel_o[c] <= wdata_i[(c % 4)*SEL_W +: SEL_W];
        if (word == WORD_W'(WORD_FILT))
          filt_o[c] <= wdata_i[c*FILT_W +: FILT_W];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (hit) begin
      if (word == WORD_W'(WORD_MODE)) begin
        rd_next[NUM_CH-1:0]          = edge_en_o;
        rd_next[BOTH_OFS +: NUM_CH]  = both_en_o;
        rd_next[INV_OFS +: NUM_CH]   = inv_en_o;
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (word == WORD_W'(WORD_SEL_LO + c / 4))
          rd_next[(c % 4)*SEL_W +: SEL_W] = sel_o[c];
        if (word == WORD_W'(WORD_FILT))
          rd_next[c*FILT_W +: FILT_W] = filt_o[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end
endmodule

// File: rtl/gir_chan.sv
module gir_chan
  import gir_pkg::*;
#(
  parameter int NUM_PADS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pads_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [FILT_W-1:0]   filt_i,
  input  logic                edge_en_i,
  input  logic                both_en_i,
  input  logic                inv_en_i,
  output logic                irq_o
);
  localparam int PAD_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam int CNT_W = FILT_W + 1;

  logic             raw;
  logic             cur;
  logic             prev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  trig_e            mode;
  logic             cur_v;
  logic             prev_v;

  // Selects at or above NUM_PADS read as a constant low pad.
  always_comb begin
    if ({1'b0, sel_i} < (SEL_W+1)'(NUM_PADS)) raw = pads_i[sel_i[PAD_W-1:0]];
    else                                      raw = 1'b0;
  end

  assign lim = {filt_i, 1'b0} - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= 1'b0;
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= cur;
      if (filt_i == '0) begin
        cur <= raw;
        cnt <= '0;
      end else if (raw == cur) begin
        cnt <= '0;
      end else if (cnt == lim) begin
        cur <= raw;
        cnt <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    if (both_en_i)      mode = TRIG_BOTH;
    else if (edge_en_i) mode = TRIG_EDGE;
    else                mode = TRIG_LEVEL;
  end

  // Edges are found on the stored raw samples, so a change of the invert bit
  // alone never looks like an edge.
  assign cur_v  = cur  ^ inv_en_i;
  assign prev_v = prev ^ inv_en_i;

  always_comb begin
    unique case (mode)
      TRIG_BOTH: irq_o = cur ^ prev;
      TRIG_EDGE: irq_o = cur_v & ~prev_v;
      default:   irq_o = cur_v;
    endcase
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gir_pkg::*;
#(
  parameter int NUM_PADS = 64,
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic [NUM_CH-1:0]   irq_o
);
  logic [NUM_PADS-1:0]           pads_s;
  logic [NUM_CH-1:0]             edge_en;
  logic [NUM_CH-1:0]             both_en;
  logic [NUM_CH-1:0]             inv_en;
  logic [NUM_CH-1:0][SEL_W-1:0]  sel;
  logic [NUM_CH-1:0][FILT_W-1:0] filt;

  gir_sync #(.W(NUM_PADS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pad_i),
    .q_o (pads_s)
  );

  gir_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we_i      (cfg_we),
    .addr_i    (cfg_addr),
    .wdata_i   (cfg_wdata),
    .rdata_o   (cfg_rdata),
    .edge_en_o (edge_en),
    .both_en_o (both_en),
    .inv_en_o  (inv_en),
    .sel_o     (sel),
    .filt_o    (filt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gir_chan #(.NUM_PADS(NUM_PADS)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .pads_i    (pads_s),
      .sel_i     (sel[c]),
      .filt_i    (filt[c]),
      .edge_en_i (edge_en[c]),
      .both_en_i (both_en[c]),
      .inv_en_i  (inv_en[c]),
      .irq_o     (irq_o[c])
    );
  end
endmodule

// File: rtl/gir_props.sv
module gir_props
  import gir_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             cfg_we,
  input logic [ADDR_W-1:0]                cfg_addr,
  input logic [31:0]                      cfg_rdata,
  input logic [NUM_CH-1:0]                irq_o,
  input logic [NUM_CH-1:0]                edge_en,
  input logic [NUM_CH-1:0]                both_en,
  input logic [NUM_CH-1:0]                inv_en,
  input logic [NUM_CH-1:0][SEL_W-1:0]     sel,
  input logic [NUM_CH-1:0][FILT_W-1:0]    filt
);
  logic off_map;
  assign off_map = (cfg_addr[1:0] != 2'b00) || (cfg_addr[ADDR_W-1:2] >= (ADDR_W-2)'(WORD_COUNT));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_o == '0 && cfg_rdata == '0));

  assert_offmap_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $past(off_map) |-> cfg_rdata == '0);

  assert_offmap_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && off_map) |=> ($stable(edge_en) && $stable(both_en) && $stable(inv_en)
                             && $stable(sel) && $stable(filt)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      (edge_en[c] && !both_en[c] && irq_o[c])
        |=> (!irq_o[c] || !$stable(inv_en[c]) || !$stable(edge_en[c]) || !$stable(both_en[c])));

    assert_filter_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (!edge_en[c] && !both_en[c] && filt[c] != '0 && !$stable(irq_o[c])
       && $stable(inv_en[c]) && $stable(filt[c]) && $stable(edge_en[c]) && $stable(both_en[c]))
        |=> ($stable(irq_o[c]) || !$stable(inv_en[c]) || !$stable(filt[c])
             || !$stable(edge_en[c]) || !$stable(both_en[c])));
  end
endmodule

bind gpio_irq_route gir_props #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_props (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .irq_o     (irq_o),
  .edge_en   (edge_en),
  .both_en   (both_en),
  .inv_en    (inv_en),
  .sel       (sel),
  .filt      (filt)
);

// File: tb/sim_gpio_irq_route.sv
module sim_gpio_irq_route;
  localparam int NP = 64;
  localparam int NC = 8;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pads = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;

  always #10 clk = ~clk;

  gpio_irq_route #(.NUM_PADS(NP), .NUM_CH(NC), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .pad_i(pads), .cfg_we(we), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rdata), .irq_o(irq)
  );

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int        at;
    logic [7:0] mask;
    logic [7:0] val;
    string     tag;
  } item_t;

  item_t q[$];

  // Driver side: expected output, n rising edges from now.
  task automatic expect_in(int n, logic [7:0] mask, logic [7:0] val, string tag);
    item_t it;
    it.at = cyc + n; it.mask = mask; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor side: compares a quarter period after each rising edge.
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0 && q[0].at <= cyc) begin
        it = q.pop_front();
        checks++;
        if ((irq & it.mask) !== (it.val & it.mask)) begin
          fails++;
          $display("FAIL %s: irq=%b expected=%b mask=%b", it.tag, irq, it.val, it.mask);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    step();
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    step();
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    step();
    addr = a;
    step();
    d = rdata;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) step();
    rst = 1'b0;

    // R1: reset state
    step();
    chk("R1 irq after reset", {24'h0, irq}, 32'h0);
    rd(6'h00, d); chk("R1 mode word", d, 32'h0);
    rd(6'h04, d); chk("R1 sel low word", d, 32'h0);
    rd(6'h08, d); chk("R1 sel high word", d, 32'h0);
    rd(6'h0c, d); chk("R1 filter word", d, 32'h0);

    // R2: channel n watches pad 3n+1
    wr(6'h04, 32'h0A07_0401);
    wr(6'h08, 32'h1613_100D);
    rd(6'h04, d); chk("R2 sel low readback", d, 32'h0A07_0401);
    rd(6'h08, d); chk("R2 sel high readback", d, 32'h1613_100D);

    // R3: off-map accesses
    rd(6'h10, d); chk("R3 read 0x10", d, 32'h0);
    rd(6'h05, d); chk("R3 misaligned read", d, 32'h0);
    wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h01, 32'hFFFF_FFFF);
    rd(6'h00, d); chk("R3 mode untouched", d, 32'h0);
    rd(6'h0c, d); chk("R3 filter untouched", d, 32'h0);
    expect_in(1, 8'hFF, 8'h00, "R3 outputs quiet after off-map writes");
    drain();

    // R2: mode word; ch1 level-low, ch2 rise, ch3 fall, ch4 both+edge+inv, ch6 both
    wr(6'h00, 32'hFF1A_501C);
    expect_in(1, 8'h02, 8'h02, "R5 level-low idle high");
    rd(6'h00, d); chk("R2 mode readback, upper bits zero", d, 32'h001A_501C);
    drain();

    // R4 level-high ch0, pad 1
    step(); pads[1] = 1'b1;
    expect_in(2, 8'h01, 8'h00, "R4 not yet after two edges");
    expect_in(3, 8'h01, 8'h01, "R4 level-high rises");
    drain();
    step(); pads[1] = 1'b0;
    expect_in(3, 8'h01, 8'h00, "R4 level-high falls");
    drain();

    // R5 level-low ch1, pad 4
    step(); pads[4] = 1'b1;
    expect_in(3, 8'h02, 8'h00, "R5 level-low pad high");
    drain();
    step(); pads[4] = 1'b0;
    expect_in(3, 8'h02, 8'h02, "R5 level-low pad low");
    drain();

    // R6 rising ch2, pad 7
    step(); pads[7] = 1'b1;
    expect_in(2, 8'h04, 8'h00, "R6 no pulse early");
    expect_in(3, 8'h04, 8'h04, "R6 rising pulse");
    expect_in(4, 8'h04, 8'h00, "R6 pulse one cycle");
    drain();
    step(); pads[7] = 1'b0;
    expect_in(3, 8'h04, 8'h00, "R6 fall ignored");
    expect_in(4, 8'h04, 8'h00, "R6 fall ignored later");
    drain();

    // R7 falling ch3, pad 10
    step(); pads[10] = 1'b1;
    expect_in(3, 8'h08, 8'h00, "R7 rise ignored");
    expect_in(4, 8'h08, 8'h00, "R7 rise ignored later");
    drain();
    step(); pads[10] = 1'b0;
    expect_in(3, 8'h08, 8'h08, "R7 falling pulse");
    expect_in(4, 8'h08, 8'h00, "R7 pulse one cycle");
    drain();

    // R8 both-edge with precedence ch4 (pad 13), both only ch6 (pad 19)
    step(); pads[13] = 1'b1; pads[19] = 1'b1;
    expect_in(3, 8'h50, 8'h50, "R8 both-edge rise pulse");
    expect_in(4, 8'h50, 8'h00, "R8 rise pulse one cycle");
    drain();
    step(); pads[13] = 1'b0; pads[19] = 1'b0;
    expect_in(3, 8'h50, 8'h50, "R8 both-edge fall pulse");
    expect_in(4, 8'h50, 8'h00, "R8 fall pulse one cycle");
    drain();

    // R4/R6 two channels at once
    step(); pads[1] = 1'b1; pads[7] = 1'b1;
    expect_in(3, 8'h05, 8'h05, "R4 R6 simultaneous");
    expect_in(4, 8'h05, 8'h01, "R4 R6 simultaneous next");
    drain();
    step(); pads[1] = 1'b0; pads[7] = 1'b0;
    expect_in(3, 8'h05, 8'h00, "R4 simultaneous release");
    drain();

    // R9 filter F=2 on ch5 (pad 16, level-high)
    wr(6'h0c, 32'h0020_0000);
    rd(6'h0c, d); chk("R9 filter readback", d, 32'h0020_0000);
    step(); pads[16] = 1'b1;
    for (int k = 1; k <= 9; k++) expect_in(k, 8'h20, 8'h00, "R9 short glitch dropped");
    repeat (3) step();
    pads[16] = 1'b0;
    drain();
    repeat (3) step();
    step(); pads[16] = 1'b1;
    expect_in(5, 8'h20, 8'h00, "R9 not before window");
    expect_in(6, 8'h20, 8'h20, "R9 accepted after window");
    drain();
    step(); pads[16] = 1'b0;
    expect_in(5, 8'h20, 8'h20, "R9 release held");
    expect_in(6, 8'h20, 8'h00, "R9 release accepted");
    drain();

    // R10 reselect ch0 from pad 1 (low) to pad 30 (high)
    step(); pads[30] = 1'b1;
    repeat (4) step();
    wr(6'h04, 32'h0A07_041E);
    expect_in(1, 8'h03, 8'h03, "R10 new pad seen, ch1 kept");
    rd(6'h04, d); chk("R10 neighbour fields kept", d, 32'h0A07_041E);
    drain();
    step(); pads[30] = 1'b0; pads[1] = 1'b1;
    expect_in(3, 8'h01, 8'h00, "R10 follows new pad only");
    drain();

    repeat (2) step();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule